// File: doc/BRIEF.md
# Programmable 16-bit Down-Count Timer

This block is a down-counting timer/counter for a peripheral device. Software writes a 16-bit reload value as a low byte and a high byte, then writes a control byte that picks the count source, starts or pauses the counter, picks one-shot or auto-reload behaviour, enables the interrupt and optionally steers the timeout onto general I/O pin 0. The count source is either a one-cycle-wide internal oscillator tick or rising edges of an asynchronous external clock pin, which is synchronised into the system clock domain.

Each timeout sets a sticky flag. The flag drives an interrupt request when the interrupt is enabled, together with the source code 7 for the device's channel 0 interrupt field. It also drives the I/O pin output when routing is selected and the pin is not claimed for another use. Reading the control register clears the flag.

Top module: `tmr16`

## Requirements
- R1: While running in auto-reload mode (control bit 2 = 0), the counter steps down once per count tick. A timeout occurs on the tick that finds the count at 1 or 0, and on that tick the counter reloads from {high byte at address 2, low byte at address 1}. Timeouts therefore repeat every max(reload,1) ticks.
- R2: A read of address 0 returns control bits 4:0 in bits 4:0 and zero in bits 7:5. Addresses 1 and 2 read back the reload low and high bytes, and address 3 reads zero. Writes to bits 7:5 of the control byte have no effect.
- R3: A control write with bit 1 = 1 loads the counter from the reload value, whether the counter is stopped or already running. A load takes precedence over a tick in the same cycle. With bit 1 = 0 the counter holds its value and no timeout occurs.
- R4: In one-shot mode (control bit 2 = 1), a timeout sets the flag, clears control bit 1 and leaves the counter at 0. No further timeout occurs until the next start.
- R5: With control bit 3 = 0, the counter counts cycles in which int_tick_i is high. With bit 3 = 1, it counts rising edges of ext_clk_i after a two-flop synchroniser, and int_tick_i is ignored.
- R6: A timeout sets a sticky flag. irq_o equals the flag ANDed with control bit 0. A read of address 0 clears the flag one cycle later, unless a timeout occurs in that same cycle.
- R7: pin_o equals the flag when control bit 4 = 1 and pin_sel_i = 0. Otherwise pin_o is 0.
- R8: src_code_o is 3'd7 while irq_o is high and 3'd0 otherwise.
- R9: After reset, all registers are zero: the counter is stopped, the interrupt is disabled, and irq_o, pin_o and src_code_o are 0.
- R10: A reload-byte write while the counter is running does not change the period in progress. It takes effect at the next reload or start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_tick_i | input | 1 | Internal oscillator count tick, one clock wide |
| ext_clk_i | input | 1 | Asynchronous external count clock |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| pin_sel_i | input | 1 | I/O pin 0 select bit; routing is allowed only when 0 |
| irq_o | output | 1 | Timer interrupt request |
| src_code_o | output | 3 | Interrupt source code, 7 when irq_o is high |
| pin_o | output | 1 | Timeout flag routed to I/O pin 0 |

## Verification
Auto-reload mode is driven with a continuous internal tick, and the expected timeout cycles are worked out by hand. This separates off-by-one errors in the period from errors in the reload path. A stop followed by a long idle shows that a pause really holds the count. The restart that follows shows that start reloads the counter rather than resuming it. One-shot mode is tried after a reload of 3 to show that it stops, while the external source is tried with a steady internal tick plus discrete pin pulses to show that the source select ignores the unselected input. A reload change in the middle of a period shows that the new value only takes effect at the next reload.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
    localparam int ADR_CTRL = 0;
    localparam int ADR_RLO  = 1;
    localparam int ADR_RHI  = 2;
    localparam int IRQ_CODE = 7;

    // control byte bits 4:0, bit positions are software visible
    typedef struct packed {
        logic route;    // 4
        logic ext_src;  // 3
        logic oneshot;  // 2
        logic run;      // 1
        logic irq_en;   // 0
    } ctrl_t;
endpackage

// File: rtl/tmr16_edge_sync.sv
module tmr16_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    localparam int W = STAGES + 1;

    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[W-2:0], async_i};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/tmr16_counter.sv
module tmr16_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic             expire_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             at_end;

    always_comb begin
        at_end   = (cnt_q <= ONE);
        expire_o = step_i && !load_i && at_end;
        cnt_d    = cnt_q;
        if (load_i)
            cnt_d = reload_i;
        else if (step_i)
            cnt_d = at_end ? (oneshot_i ? '0 : reload_i) : cnt_q - ONE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/tmr16.sv
module tmr16
    import tmr16_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              int_tick_i,
    input  logic              ext_clk_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic              pin_sel_i,
    output logic              irq_o,
    output logic [2:0]        src_code_o,
    output logic              pin_o
);
    localparam int CNT_W  = 2 * DATA_W;
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [DATA_W-1:0] rlo;
        logic [DATA_W-1:0] rhi;
        logic              flag;
    } state_t;

    state_t s_d, s_q;
    logic   ext_rise, tick, load, step, expire;
    logic   ctrl_wr, ctrl_rd;

    tmr16_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_clk_i),
        .rise_o  (ext_rise)
    );

    tmr16_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load),
        .step_i    (step),
        .oneshot_i (s_q.ctrl.oneshot),
        .reload_i  ({s_q.rhi, s_q.rlo}),
        .expire_o  (expire)
    );

    always_comb begin
        ctrl_wr = wr_en_i && (addr_i == ADDR_W'(ADR_CTRL));
        ctrl_rd = rd_en_i && (addr_i == ADDR_W'(ADR_CTRL));
        tick    = s_q.ctrl.ext_src ? ext_rise : int_tick_i;
        load    = ctrl_wr && wdata_i[1];
        step    = s_q.ctrl.run && tick;

        s_d = s_q;
        if (wr_en_i && addr_i == ADDR_W'(ADR_RLO)) s_d.rlo = wdata_i;
        if (wr_en_i && addr_i == ADDR_W'(ADR_RHI)) s_d.rhi = wdata_i;
        if (ctrl_wr)
            s_d.ctrl = ctrl_t'(wdata_i[CTRL_W-1:0]);
        else if (expire && s_q.ctrl.oneshot)
            s_d.ctrl.run = 1'b0;
        if (ctrl_rd) s_d.flag = 1'b0;
        if (expire)  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (addr_i)
            ADDR_W'(ADR_CTRL): rdata_o = {{(DATA_W-CTRL_W){1'b0}}, s_q.ctrl};
            ADDR_W'(ADR_RLO):  rdata_o = s_q.rlo;
            ADDR_W'(ADR_RHI):  rdata_o = s_q.rhi;
            default:           rdata_o = '0;
        endcase
    end

    assign irq_o      = s_q.flag && s_q.ctrl.irq_en;
    assign src_code_o = irq_o ? 3'(IRQ_CODE) : 3'd0;
    assign pin_o      = s_q.flag && s_q.ctrl.route && !pin_sel_i;
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              pin_sel_i,
    input logic              irq_o,
    input logic [2:0]        src_code_o,
    input logic              pin_o,
    input logic              expire,
    input logic              flag,
    input logic [4:0]        ctrl
);
    logic ctl_acc_wr, ctl_acc_rd;
    assign ctl_acc_wr = wr_en_i && addr_i == '0;
    assign ctl_acc_rd = rd_en_i && addr_i == '0;

    assert_timeout_sets_flag_R1: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc_wr |=> ({{(DATA_W-5){1'b0}}, ctrl} == ($past(wdata_i) & DATA_W'(8'h1F))));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_acc_rd |-> rdata_o[DATA_W-1:5] == '0);

    assert_oneshot_stops_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl[2] && !ctl_acc_wr) |=> !ctrl[1]);

    assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_acc_rd && !expire) |=> !flag);

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ctl_acc_rd) |=> flag);

    assert_irq_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[0] |-> !irq_o);

    assert_pin_blocked_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pin_sel_i |-> !pin_o);

    assert_code_on_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> src_code_o == 3'd7);

    assert_code_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> src_code_o == 3'd0);
endmodule

bind tmr16 tmr16_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_tmr16_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .pin_sel_i  (pin_sel_i),
    .irq_o      (irq_o),
    .src_code_o (src_code_o),
    .pin_o      (pin_o),
    .expire     (expire),
    .flag       (s_q.flag),
    .ctrl       (s_q.ctrl)
);

// File: tb/tmr16_bench.sv
module tmr16_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       int_tick = 1'b0, ext_clk = 1'b0;
    logic       wr_en = 1'b0, rd_en = 1'b0, pin_sel = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, pin;
    logic [2:0] code;

    int total = 0, bad = 0, cycles = 0;
    bit done = 0;

    always #4 clk = ~clk;

    tmr16 u_tmr16 (
        .clk(clk), .rst_n(rst_n), .int_tick_i(int_tick), .ext_clk_i(ext_clk),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .pin_sel_i(pin_sel), .irq_o(irq), .src_code_o(code),
        .pin_o(pin)
    );

    // behavioural reference model
    int   m_cnt, m_reload;
    bit   m_ien, m_run, m_one, m_ext, m_route, m_flag;
    bit [7:0] m_lo, m_hi;
    bit   sy1, sy2, sy3;

    always @(posedge clk) begin
        bit tk, ld, st, ex;
        if (!rst_n) begin
            m_cnt = 0; m_ien = 0; m_run = 0; m_one = 0; m_ext = 0; m_route = 0;
            m_flag = 0; m_lo = 0; m_hi = 0; sy1 = 0; sy2 = 0; sy3 = 0;
        end else begin
            m_reload = m_hi * 256 + m_lo;
            tk = m_ext ? (sy2 && !sy3) : int_tick;
            ld = wr_en && addr == 0 && wdata[1];
            st = m_run && tk && !ld;
            ex = st && m_cnt <= 1;
            if (ld) m_cnt = m_reload;
            else if (ex) m_cnt = m_one ? 0 : m_reload;
            else if (st) m_cnt = m_cnt - 1;
            if (rd_en && addr == 0) m_flag = 0;
            if (ex) m_flag = 1;
            if (wr_en && addr == 0) begin
                m_ien = wdata[0]; m_run = wdata[1]; m_one = wdata[2];
                m_ext = wdata[3]; m_route = wdata[4];
            end else if (ex && m_one) m_run = 0;
            if (wr_en && addr == 1) m_lo = wdata;
            if (wr_en && addr == 2) m_hi = wdata;
            sy3 = sy2; sy2 = sy1; sy1 = ext_clk;
        end
    end

    function automatic logic [7:0] m_rdata(input logic [1:0] a);
        case (a)
            2'd0: return {3'b000, m_route, m_ext, m_one, m_run, m_ien};
            2'd1: return m_lo;
            2'd2: return m_hi;
            default: return 8'd0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R6 irq vs model", {7'd0, irq}, {7'd0, m_flag && m_ien});
            chk("R7 pin vs model", {7'd0, pin}, {7'd0, m_flag && m_route && !pin_sel});
            chk("R8 code vs model", {5'd0, code}, (m_flag && m_ien) ? 8'd7 : 8'd0);
            chk("R2 rdata vs model", rdata, m_rdata(addr));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected<=100000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 0; addr = 0; wdata = 0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
        rd_en = 1; addr = a;
        #1 chk(tag, rdata, exp);
        @(negedge clk);
        rd_en = 0; addr = 0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_pulse();
        ext_clk = 1; waitn(3);
        ext_clk = 0; waitn(3);
    endtask

    initial begin
        waitn(4);
        rst_n = 1;
        // R9 reset state
        chk("R9 irq after reset", {7'd0, irq}, 8'd0);
        chk("R9 pin after reset", {7'd0, pin}, 8'd0);
        chk("R9 code after reset", {5'd0, code}, 8'd0);
        rd(2'd0, 8'h00, "R9 ctrl after reset");
        rd(2'd1, 8'h00, "R9 reload lo after reset");

        // R1/R2 auto-reload with internal tick
        wr(2'd1, 8'd5);
        wr(2'd2, 8'd0);
        rd(2'd1, 8'd5, "R2 reload lo readback");
        rd(2'd2, 8'd0, "R2 reload hi readback");
        rd(2'd3, 8'd0, "R2 unused address reads zero");
        int_tick = 1;
        wr(2'd0, 8'hE3);
        waitn(4);
        chk("R1 no timeout before 5 ticks", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R1 timeout after 5 ticks", {7'd0, irq}, 8'd1);
        chk("R8 code 7 with irq", {5'd0, code}, 8'd7);
        rd(2'd0, 8'h03, "R2 reserved bits read zero");
        chk("R6 read clears flag", {7'd0, irq}, 8'd0);
        waitn(3);
        chk("R1 no early repeat", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R1 repeat after reload", {7'd0, irq}, 8'd1);

        // R6/R7 masking and routing
        int_tick = 0;
        wr(2'd0, 8'h02);
        chk("R6 flag kept but irq masked", {7'd0, irq}, 8'd0);
        chk("R8 code zero when masked", {5'd0, code}, 8'd0);
        chk("R7 pin off without route", {7'd0, pin}, 8'd0);
        wr(2'd0, 8'h12);
        chk("R7 pin follows flag when routed", {7'd0, pin}, 8'd1);
        pin_sel = 1;
        #1 chk("R7 pin blocked by select", {7'd0, pin}, 8'd0);
        @(negedge clk);
        pin_sel = 0;
        rd(2'd0, 8'h12, "R2 ctrl readback");
        chk("R7 pin clears with flag", {7'd0, pin}, 8'd0);

        // R3 pause and restart
        wr(2'd0, 8'h03);
        int_tick = 1;
        waitn(2);
        wr(2'd0, 8'h01);
        waitn(20);
        chk("R3 paused counter never times out", {7'd0, irq}, 8'd0);
        wr(2'd0, 8'h03);
        waitn(4);
        chk("R3 restart reloads, no early timeout", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R3 restart full period", {7'd0, irq}, 8'd1);

        // R4 one-shot
        rd(2'd0, 8'h03, "R6 clear before one-shot");
        int_tick = 0;
        wr(2'd1, 8'd3);
        wr(2'd0, 8'h07);
        int_tick = 1;
        waitn(2);
        chk("R4 one-shot not yet", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R4 one-shot timeout", {7'd0, irq}, 8'd1);
        rd(2'd0, 8'h05, "R4 run bit cleared after one-shot");
        waitn(20);
        chk("R4 no second timeout", {7'd0, irq}, 8'd0);

        // R5 external source
        wr(2'd1, 8'd2);
        wr(2'd0, 8'h0B);
        waitn(10);
        chk("R5 internal tick ignored in external mode", {7'd0, irq}, 8'd0);
        ext_pulse();
        chk("R5 one external edge", {7'd0, irq}, 8'd0);
        ext_pulse();
        chk("R5 second external edge times out", {7'd0, irq}, 8'd1);

        // R10 reload change mid-period
        rd(2'd0, 8'h0B, "R6 clear before reload test");
        int_tick = 0;
        wr(2'd1, 8'd4);
        wr(2'd0, 8'h03);
        int_tick = 1;
        wr(2'd1, 8'd2);
        waitn(2);
        chk("R10 old period still running", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R10 first period uses old reload", {7'd0, irq}, 8'd1);
        rd(2'd0, 8'h03, "R6 clear mid test");
        chk("R10 flag cleared", {7'd0, irq}, 8'd0);
        waitn(1);
        chk("R10 next period uses new reload", {7'd0, irq}, 8'd1);

        waitn(5);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule